// File: doc/BRIEF.md
# Single-Precision Rounding Stage

This block is the final stage shared by floating-point datapaths such as an adder or a multiplier. The upstream logic has already aligned, computed and normalized the result. It hands over a sign, a wide signed biased exponent, a 24-bit significand with the hidden one in the top bit, and three extra bits below the fraction: guard, round and sticky. The stage applies one of four rounding directions and returns the packed 32-bit single-precision word. Its flags report inexactness and overflow.

An increment that carries out of the significand renormalizes the value: the significand becomes one again and the exponent grows by one. When the rounded exponent reaches the all-ones code, the result saturates. It becomes either a signed infinity or the largest finite magnitude, as the mode and the sign select. A parameter chooses a one-cycle output register (the default) or a purely combinational path.

Top module: `fp_round_unit`

## Requirements
- R1: With mode 2'b00 (nearest, ties to even), the significand is incremented when the bits below the fraction are above half (guard=1 and round or sticky set) and truncated when they are below half (guard=0).
- R2: With mode 2'b00, an exact tie (guard=1, round=0, sticky=0) increments only when the fraction LSB (result bit 0 before rounding) is 1, so the result LSB is always 0 afterwards.
- R3: With mode 2'b01 (toward zero), the fraction and exponent pass through unchanged for any guard, round and sticky value.
- R4: With mode 2'b10 (toward plus infinity), the significand is incremented when the sign is 0 and any of guard, round, sticky is 1, and never when the sign is 1.
- R5: With mode 2'b11 (toward minus infinity), the significand is incremented when the sign is 1 and any of guard, round, sticky is 1, and never when the sign is 0.
- R6: An increment of an all-ones significand yields fraction field 0 and exponent field equal to the input exponent plus one.
- R7: When the rounded exponent is 255 or more, overflow is 1. With mode 2'b00 the result is a signed infinity: exponent field 255 (bits 30:23) and fraction 0.
- R8: On overflow with mode 2'b01, the result is the largest finite magnitude: exponent field 254 and an all-ones fraction, with the input sign.
- R9: On overflow, mode 2'b10 gives +infinity for sign 0 and the largest finite negative value for sign 1. Mode 2'b11 gives -infinity for sign 1 and the largest finite positive value for sign 0.
- R10: The inexact flag equals the OR of guard, round and sticky.
- R11: With the output register enabled, results appear one clock after the inputs. While rst_n is low, the result and both flags are 0.
- R12: Without overflow, the overflow flag is 0, the sign bit (bit 31) equals the input sign, and the exponent field is the low 8 bits of the rounded exponent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous active-low reset |
| sign_i | input | 1 | Sign of the result |
| exp_i | input | 10 | Signed biased exponent, assumed at least 1 |
| sig_i | input | 24 | Normalized significand, bit 23 is the hidden one |
| guard_i | input | 1 | First bit below the fraction LSB |
| round_i | input | 1 | Second bit below the fraction LSB |
| sticky_i | input | 1 | OR of all lower discarded bits |
| mode_i | input | 2 | Rounding mode: 00 nearest even, 01 toward zero, 10 toward +inf, 11 toward -inf |
| result_o | output | 32 | Packed single-precision result |
| inexact_o | output | 1 | Some discarded bit was nonzero |
| overflow_o | output | 1 | Rounded exponent exceeded the finite range |

## Verification
A wrong increment decision shows up as an LSB that is off by one in result_o on the very next cycle. For all-ones significands the same error spreads into the exponent field. A fault in the renormalization or saturation path gives an exponent or fraction of the wrong form: a NaN pattern, a zero where a maximum belongs, or an infinity in the wrong direction. This also appears one cycle after the offending inputs. No state persists between operands, so every fault is visible on the vector that triggers it.

// File: rtl/fpr_pkg.sv
// Shared types for the rounding stage.
// Assumes: the mode encoding below is the one seen at the top-level port.
package fpr_pkg;
    typedef enum logic [1:0] {
        RM_NEAR_EVEN = 2'b00,
        RM_TO_ZERO   = 2'b01,
        RM_TO_POS    = 2'b10,
        RM_TO_NEG    = 2'b11
    } rmode_e;
endpackage

// File: rtl/fpr_incr_decide.sv
// Decides whether the truncated significand must be bumped by one ulp.
// Assumes: guard/round/sticky are already aligned below the fraction LSB.
module fpr_incr_decide
    import fpr_pkg::*;
(
    input  rmode_e mode_i,
    input  logic   sign_i,
    input  logic   lsb_i,
    input  logic   guard_i,
    input  logic   round_i,
    input  logic   sticky_i,
    output logic   inc_o
);
    logic any_low;

    // Pick the increment rule for the selected mode.
    always_comb begin
        any_low = guard_i | round_i | sticky_i;
        unique case (mode_i)
            RM_NEAR_EVEN: inc_o = guard_i & (round_i | sticky_i | lsb_i);
            RM_TO_ZERO:   inc_o = 1'b0;
            RM_TO_POS:    inc_o = ~sign_i & any_low;
            RM_TO_NEG:    inc_o = sign_i & any_low;
            default:      inc_o = 1'b0;
        endcase
    end

    // Exact inputs never round, whatever the mode (R3 covers truncation).
    always_comb begin
        if (!(guard_i | round_i | sticky_i))
            a_r3_exact_no_inc: assert (!inc_o);
        if (mode_i == RM_TO_ZERO)
            a_r3_toward_zero_truncates: assert (!inc_o);
    end
endmodule

// File: rtl/fpr_sig_adjust.sv
// Adds the rounding increment and renormalizes on carry-out.
// Assumes: sig_i has its hidden one set (normalized input).
module fpr_sig_adjust #(
    parameter int FRAC_W = 23,
    parameter int EXPI_W = 10
) (
    input  logic signed [EXPI_W-1:0] exp_i,
    input  logic        [FRAC_W:0]   sig_i,
    input  logic                     inc_i,
    output logic signed [EXPI_W-1:0] exp_o,
    output logic        [FRAC_W-1:0] frac_o
);
    localparam int SIG_W = FRAC_W + 1;

    logic [SIG_W:0] sum;

    // Increment, then shift right by one and bump the exponent on carry-out.
    always_comb begin
        sum = {1'b0, sig_i} + {{SIG_W{1'b0}}, inc_i};
        if (sum[SIG_W]) begin
            frac_o = sum[SIG_W-1:1];
            exp_o  = exp_i + EXPI_W'(1);
        end else begin
            frac_o = sum[FRAC_W-1:0];
            exp_o  = exp_i;
        end
    end

    // Exponent and fraction read as one integer move up by exactly the increment (R6).
    always_comb begin
        a_r6_renorm_is_plus_one: assert ({exp_o, frac_o} ==
            ({exp_i, sig_i[FRAC_W-1:0]} + {{(EXPI_W+FRAC_W-1){1'b0}}, inc_i}));
    end
endmodule

// File: rtl/fpr_pack_sat.sv
// Detects exponent overflow, saturates per mode and sign, and packs the word.
// Assumes: exp_i is at least 1; lower exponents are outside the contract.
module fpr_pack_sat
    import fpr_pkg::*;
#(
    parameter int FRAC_W = 23,
    parameter int EXP_W  = 8,
    parameter int EXPI_W = 10
) (
    input  rmode_e                        mode_i,
    input  logic                          sign_i,
    input  logic signed [EXPI_W-1:0]      exp_i,
    input  logic        [FRAC_W-1:0]      frac_i,
    output logic        [EXP_W+FRAC_W:0]  result_o,
    output logic                          ovf_o
);
    localparam logic signed [EXPI_W-1:0] EXP_TOP = EXPI_W'((1 << EXP_W) - 1);
    localparam logic [EXP_W-1:0]  EXP_ONES = {EXP_W{1'b1}};
    localparam logic [EXP_W-1:0]  EXP_MAXF = {{(EXP_W-1){1'b1}}, 1'b0};

    logic to_inf;

    // Choose infinity or the largest finite value, otherwise pack as is.
    always_comb begin
        ovf_o  = (exp_i >= EXP_TOP);
        to_inf = (mode_i == RM_NEAR_EVEN)
               | ((mode_i == RM_TO_POS) & ~sign_i)
               | ((mode_i == RM_TO_NEG) &  sign_i);
        if (!ovf_o)
            result_o = {sign_i, exp_i[EXP_W-1:0], frac_i};
        else if (to_inf)
            result_o = {sign_i, EXP_ONES, {FRAC_W{1'b0}}};
        else
            result_o = {sign_i, EXP_MAXF, {FRAC_W{1'b1}}};
    end

    // A saturated result is infinity or the largest finite value, never a NaN (R7, R8).
    always_comb begin
        if (ovf_o)
            a_r7_sat_form: assert (
                (result_o[FRAC_W+EXP_W-1:FRAC_W] == EXP_ONES && result_o[FRAC_W-1:0] == '0) ||
                (result_o[FRAC_W+EXP_W-1:FRAC_W] == EXP_MAXF && result_o[FRAC_W-1:0] == '1));
        if (!ovf_o && exp_i > 0)
            a_r12_finite_exp: assert (result_o[FRAC_W+EXP_W-1:FRAC_W] != EXP_ONES);
    end
endmodule

// File: rtl/fp_round_unit.sv
// Four-mode rounding stage for single precision: decides, increments, saturates.
// Assumes: normalized significand, exponent >= 1, guard/round/sticky from upstream.
module fp_round_unit
    import fpr_pkg::*;
#(
    parameter int FRAC_W  = 23,
    parameter int EXP_W   = 8,
    parameter int EXPI_W  = 10,
    parameter bit OUT_REG = 1'b1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sign_i,
    input  logic signed [EXPI_W-1:0] exp_i,
    input  logic        [FRAC_W:0]   sig_i,
    input  logic                     guard_i,
    input  logic                     round_i,
    input  logic                     sticky_i,
    input  logic        [1:0]        mode_i,
    output logic [EXP_W+FRAC_W:0]    result_o,
    output logic                     inexact_o,
    output logic                     overflow_o
);
    localparam int RES_W = 1 + EXP_W + FRAC_W;

    rmode_e                    mode;
    logic                      inc;
    logic signed [EXPI_W-1:0]  exp_adj;
    logic        [FRAC_W-1:0]  frac_adj;
    logic        [RES_W-1:0]   res_c;
    logic                      ovf_c;
    logic                      inx_c;

    assign mode  = rmode_e'(mode_i);
    assign inx_c = guard_i | round_i | sticky_i;

    fpr_incr_decide u_decide (
        .mode_i   (mode),
        .sign_i   (sign_i),
        .lsb_i    (sig_i[0]),
        .guard_i  (guard_i),
        .round_i  (round_i),
        .sticky_i (sticky_i),
        .inc_o    (inc)
    );

    fpr_sig_adjust #(.FRAC_W(FRAC_W), .EXPI_W(EXPI_W)) u_adjust (
        .exp_i  (exp_i),
        .sig_i  (sig_i),
        .inc_i  (inc),
        .exp_o  (exp_adj),
        .frac_o (frac_adj)
    );

    fpr_pack_sat #(.FRAC_W(FRAC_W), .EXP_W(EXP_W), .EXPI_W(EXPI_W)) u_pack (
        .mode_i   (mode),
        .sign_i   (sign_i),
        .exp_i    (exp_adj),
        .frac_i   (frac_adj),
        .result_o (res_c),
        .ovf_o    (ovf_c)
    );

    generate
        if (OUT_REG) begin : g_reg
            logic run_q;

            // Capture the rounded word and flags; clear them in reset.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    result_o   <= '0;
                    inexact_o  <= 1'b0;
                    overflow_o <= 1'b0;
                    run_q      <= 1'b0;
                end else begin
                    result_o   <= res_c;
                    inexact_o  <= inx_c;
                    overflow_o <= ovf_c;
                    run_q      <= 1'b1;
                end
            end

            a_r10_inexact_follows: assert property (@(posedge clk) disable iff (!rst_n)
                run_q |-> (inexact_o == $past(guard_i | round_i | sticky_i)));
            a_r12_sign_follows: assert property (@(posedge clk) disable iff (!rst_n)
                run_q |-> (result_o[RES_W-1] == $past(sign_i)));
            a_r3_zero_mode_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
                (run_q && $past(mode_i) == 2'b01 && !overflow_o) |->
                (result_o[FRAC_W-1:0] == $past(sig_i[FRAC_W-1:0])));
        end else begin : g_comb
            assign result_o   = res_c;
            assign inexact_o  = inx_c;
            assign overflow_o = ovf_c;
        end
    endgenerate
endmodule

// File: tb/fp_round_unit_bench.sv
module fp_round_unit_bench;
    localparam int CLK_PERIOD = 10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sign_i = 1'b0;
    logic signed [9:0] exp_i = 10'sd127;
    logic [23:0]       sig_i = 24'h800000;
    logic              guard_i = 1'b0, round_i = 1'b0, sticky_i = 1'b0;
    logic [1:0]        mode_i = 2'b00;
    logic [31:0]       result_o;
    logic              inexact_o, overflow_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fp_round_unit u_fp_round_unit (
        .clk(clk), .rst_n(rst_n), .sign_i(sign_i), .exp_i(exp_i), .sig_i(sig_i),
        .guard_i(guard_i), .round_i(round_i), .sticky_i(sticky_i), .mode_i(mode_i),
        .result_o(result_o), .inexact_o(inexact_o), .overflow_o(overflow_o)
    );

    // Reference: treat exponent:fraction as one magnitude and add the ulp decided from the tail.
    function automatic logic [33:0] model(input logic s, input logic signed [9:0] e,
                                          input logic [23:0] sg, input logic [2:0] grs,
                                          input logic [1:0] m);
        logic up;
        longint mag;
        logic [31:0] w;
        logic ov;
        case (m)
            2'b00: up = (grs > 3'd4) || (grs == 3'd4 && sg[0]);
            2'b01: up = 1'b0;
            2'b10: up = (grs != 0) && !s;
            default: up = (grs != 0) && s;
        endcase
        mag = longint'(e) * 64'sd8388608 + longint'(sg[22:0]) + (up ? 64'sd1 : 64'sd0);
        ov = (mag >= 64'sd255 * 64'sd8388608);
        if (!ov) w = {s, 8'(mag >>> 23), 23'(mag)};
        else if (m == 2'b00 || (m == 2'b10 && !s) || (m == 2'b11 && s))
            w = {s, 8'hFF, 23'h0};
        else w = {s, 8'hFE, 23'h7FFFFF};
        return {w, (grs != 0), ov};
    endfunction

    task automatic check(input string tag, input logic [33:0] act, input logic [33:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got res=%h inx=%b ovf=%b, want res=%h inx=%b ovf=%b",
                     tag, act[33:2], act[1], act[0], exp[33:2], exp[1], exp[0]);
        end
    endtask

    // Apply one vector, wait for the register edge, compare at the following falling edge.
    task automatic run_vec(input string tag, input logic s, input logic signed [9:0] e,
                           input logic [23:0] sg, input logic [2:0] grs, input logic [1:0] m);
        @(negedge clk);
        sign_i = s; exp_i = e; sig_i = sg; mode_i = m;
        {guard_i, round_i, sticky_i} = grs;
        @(negedge clk);
        check(tag, {result_o, inexact_o, overflow_o}, model(s, e, sg, grs, m));
    endtask

    function automatic string mode_tag(input logic [1:0] m, input logic [2:0] grs);
        case (m)
            2'b00: return (grs == 3'd4) ? "R2" : "R1";
            2'b01: return "R3";
            2'b10: return "R4";
            default: return "R5";
        endcase
    endfunction

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got hung run, want completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        // R11: reset holds outputs at zero despite live inputs.
        sign_i = 1'b1; guard_i = 1'b1; exp_i = 10'sd300;
        repeat (3) @(negedge clk);
        check("R11", {result_o, inexact_o, overflow_o}, 34'h0);
        rst_n = 1'b1;

        // Exhaustive tail x sign x mode x LSB sweep (R1..R5, R10).
        for (int m = 0; m < 4; m++)
            for (int s = 0; s < 2; s++)
                for (int l = 0; l < 2; l++)
                    for (int g = 0; g < 8; g++)
                        run_vec(mode_tag(2'(m), 3'(g)), 1'(s), 10'sd127,
                                {1'b1, 22'h2A5F3C, 1'(l)}, 3'(g), 2'(m));

        // R6: all-ones significand carries into the exponent.
        for (int m = 0; m < 4; m++)
            for (int s = 0; s < 2; s++) begin
                run_vec("R6", 1'(s), 10'sd100, 24'hFFFFFF, 3'b110, 2'(m));
                run_vec("R6", 1'(s), 10'sd1, 24'hFFFFFF, 3'b100, 2'(m));
            end

        // R7/R8/R9: overflow by carry from 254 and by a large input exponent.
        for (int s = 0; s < 2; s++) begin
            run_vec("R7", 1'(s), 10'sd254, 24'hFFFFFF, 3'b111, 2'b00);
            run_vec("R7", 1'(s), 10'sd300, 24'h923456, 3'b000, 2'b00);
            run_vec("R8", 1'(s), 10'sd255, 24'hC00001, 3'b101, 2'b01);
            run_vec("R8", 1'(s), 10'sd254, 24'hFFFFFF, 3'b111, 2'b01);
            run_vec("R9", 1'(s), 10'sd254, 24'hFFFFFF, 3'b001, 2'b10);
            run_vec("R9", 1'(s), 10'sd254, 24'hFFFFFF, 3'b001, 2'b11);
            run_vec("R9", 1'(s), 10'sd400, 24'h800000, 3'b000, 2'b10);
            run_vec("R9", 1'(s), 10'sd400, 24'h800000, 3'b000, 2'b11);
        end
        // R12: largest finite value survives when nothing rounds up.
        run_vec("R12", 1'b0, 10'sd254, 24'hFFFFFF, 3'b000, 2'b00);
        run_vec("R12", 1'b1, 10'sd254, 24'hFFFFFF, 3'b011, 2'b10);

        // R10/R12: constrained random operands across the finite range.
        for (int i = 0; i < 2000; i++) begin
            logic [23:0] sg;
            logic signed [9:0] e;
            sg = {1'b1, 23'($urandom)};
            if (($urandom % 8) == 0) sg[22:0] = 23'h7FFFFF;
            e = 10'($urandom_range(1, 260));
            run_vec(($urandom % 2) ? "R10" : "R12", 1'($urandom), e, sg,
                    3'($urandom), 2'($urandom));
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule